// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller

This block moves a block of words between one attached device and system memory without the processor copying each word. The processor sets up a transfer through a small register window: the direction, the device address, the first memory address and the number of words. It then sets a start bit. The controller takes the system bus for a single word at a time. For each word it raises a bus request, waits for the grant, performs one memory access and gives the bus back. The processor is never context-switched; it only waits for the bus during the stolen cycle.

The device sits next to the controller, so each word crosses the system bus once, straight between the controller and memory. Before each request the controller waits for the device to be ready, so it never holds the bus while the device stalls. After the last word a sticky done flag and the interrupt line go high. They stay high until the processor clears them. Each word moves through four phases: request, access, release with address and count update, and then either the next request or completion.

Top module: `steal_dma`

## Requirements
- R1: After reset, `bus_req`, `mem_en`, `dev_take`, `dev_put` and `irq` are low, and the status register reads 0.
- R2: Register offsets are as follows. 0 is control, with bit 0 as start (write 1) and bit 1 as direction (0 = device to memory, 1 = memory to device). 1 is the device address. 2 is the memory address. 3 is the word count. 4 is status, with bit 0 busy and bit 1 done. `reg_rdata` shows the register addressed at the previous clock edge. Offsets 2 and 3 read the live address and the remaining count.
- R3: `bus_req` rises only if `dev_ready` was high at that clock edge. Once raised, it stays high until the grant is seen.
- R4: Each grant gives exactly one cycle of `mem_en`, and `bus_req` is low in the cycle after it. The k-th word (k from 0) uses `mem_addr` = start address + k.
- R5: For device to memory, `mem_we` is 1 and `mem_wdata` is `dev_rdata` as sampled on the grant edge. `dev_take` pulses in the same cycle as `mem_en`. For memory to device, `mem_we` is 0, and `dev_wdata` takes the `mem_rdata` present during `mem_en`. `dev_put` pulses in the following cycle.
- R6: After the last word, `irq` and the done bit go high and busy goes low. The address register then reads start + count and the count reads 0.
- R7: A start with a count of 0 raises no bus request. `irq` goes high two clock edges after the start write.
- R8: While busy, a start write is ignored. Writes to control, device address, memory address and count are also ignored.
- R9: `irq` stays high until a write to status with bit 1 set. If that write falls in the cycle where completion sets the flag, the flag stays set.
- R10: `dev_sel` always carries the programmed device address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_en | output | 1 | Memory access strobe, one cycle per word |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Data written to memory |
| mem_rdata | input | DW | Memory read data, valid while `mem_en` is high |
| dev_ready | input | 1 | Device can take or give a word |
| dev_sel | output | DEVW | Programmed device address |
| dev_rdata | input | DW | Word offered by the device |
| dev_take | output | 1 | Device word consumed |
| dev_wdata | output | DW | Word delivered to the device |
| dev_put | output | 1 | `dev_wdata` valid strobe |
| irq | output | 1 | Completion interrupt |

## Verification
Assertions check these properties on every cycle:
- one memory access per ownership, with the request dropped right after it;
- a request only ever follows a ready device;
- a pending request is held until the grant arrives;
- a delivery strobe only ever follows a memory read;
- memory is never accessed with a zero count;
- the interrupt only rises once the count reaches zero and, until cleared, holds;
- programming registers stay unchanged across busy-time writes.

Only the bench scenarios can show the rest: data arriving at the right addresses in order, the exact cycle the interrupt rises for a zero count, set winning over a clear written in the same cycle, and the correct end state of address and count after stalls in both grant and device readiness.

// File: rtl/steal_dma_pkg.sv
package steal_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_XFER,
    ST_REL,
    ST_DONE
  } seq_state_t;

  // register offsets
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_DEV  = 1;
  localparam int unsigned OFS_MADR = 2;
  localparam int unsigned OFS_CNT  = 3;
  localparam int unsigned OFS_STAT = 4;

  // bit positions
  localparam int unsigned CTRL_GO   = 0;
  localparam int unsigned CTRL_DIR  = 1;
  localparam int unsigned STAT_BUSY = 0;
  localparam int unsigned STAT_DONE = 1;

endpackage

// File: rtl/steal_dma_regs.sv
module steal_dma_regs
  import steal_dma_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int DEVW = 8,
  parameter int RAW  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [DEVW-1:0] wr_lo,
  input  logic            busy,
  input  logic            done_set,
  input  logic [AW-1:0]   cur_addr,
  input  logic [CW-1:0]   cur_cnt,
  output logic [DW-1:0]   reg_rdata,
  output logic            dir,
  output logic [DEVW-1:0] dev_sel,
  output logic            done,
  output logic            go,
  output logic            ld_addr,
  output logic            ld_cnt
);

  localparam logic [RAW-1:0] A_CTRL = RAW'(OFS_CTRL);
  localparam logic [RAW-1:0] A_DEV  = RAW'(OFS_DEV);
  localparam logic [RAW-1:0] A_MADR = RAW'(OFS_MADR);
  localparam logic [RAW-1:0] A_CNT  = RAW'(OFS_CNT);
  localparam logic [RAW-1:0] A_STAT = RAW'(OFS_STAT);

  logic wr_ctrl, wr_dev, clr_done;

  // configuration writes only land while the channel is idle
  assign wr_ctrl  = reg_wr && !busy && (reg_addr == A_CTRL);
  assign wr_dev   = reg_wr && !busy && (reg_addr == A_DEV);
  assign ld_addr  = reg_wr && !busy && (reg_addr == A_MADR);
  assign ld_cnt   = reg_wr && !busy && (reg_addr == A_CNT);
  assign go       = wr_ctrl && wr_lo[CTRL_GO];
  assign clr_done = reg_wr && (reg_addr == A_STAT) && wr_lo[STAT_DONE];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir     <= 1'b0;
      dev_sel <= '0;
      done    <= 1'b0;
    end else begin
      if (wr_ctrl) dir <= wr_lo[CTRL_DIR];
      if (wr_dev)  dev_sel <= wr_lo;
      // completion outranks a simultaneous clear
      if (done_set)      done <= 1'b1;
      else if (clr_done) done <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (reg_addr)
        A_CTRL: reg_rdata[CTRL_DIR] <= dir;
        A_DEV:  reg_rdata <= DW'(dev_sel);
        A_MADR: reg_rdata <= DW'(cur_addr);
        A_CNT:  reg_rdata <= DW'(cur_cnt);
        A_STAT: begin
          reg_rdata[STAT_BUSY] <= busy;
          reg_rdata[STAT_DONE] <= done;
        end
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R8
  property p_lock;
    @(posedge clk) disable iff (rst)
      (busy && reg_wr && (reg_addr == A_DEV || reg_addr == A_CTRL)) |=> ($stable(dev_sel) && $stable(dir));
  endproperty
  cfg_lock_chk: assert property (p_lock);

  // R9
  property p_irq_hold;
    @(posedge clk) disable iff (rst)
      (done && !(reg_wr && reg_addr == A_STAT && wr_lo[STAT_DONE])) |=> done;
  endproperty
  irq_hold_chk: assert property (p_irq_hold);

endmodule

// File: rtl/steal_dma_ctr.sv
module steal_dma_ctr #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic [DW-1:0] wdata,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] cnt,
  output logic          cnt_zero,
  output logic          cnt_last
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [AW-1:0] ADR_ONE = AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      cnt  <= '0;
    end else begin
      if (ld_addr)   addr <= AW'(wdata);
      else if (step) addr <= addr + ADR_ONE;
      if (ld_cnt)    cnt <= CW'(wdata);
      else if (step) cnt <= cnt - CNT_ONE;
    end
  end

  assign cnt_zero = (cnt == '0);
  assign cnt_last = (cnt == CNT_ONE);

endmodule

// File: rtl/steal_dma_seq.sv
module steal_dma_seq
  import steal_dma_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          dir,
  input  logic          cnt_zero,
  input  logic          cnt_last,
  input  logic          dev_ready,
  input  logic          bus_gnt,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] dev_rdata,
  output logic          bus_req,
  output logic          mem_en,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          dev_take,
  output logic          dev_put,
  output logic [DW-1:0] dev_wdata,
  output logic          step,
  output logic          done_set,
  output logic          busy
);

  seq_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bus_req   <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      dev_take  <= 1'b0;
      dev_put   <= 1'b0;
      dev_wdata <= '0;
    end else begin
      dev_take <= 1'b0;
      dev_put  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go) st <= cnt_zero ? ST_DONE : ST_REQ;
        end
        ST_REQ: begin
          if (!bus_req) begin
            if (dev_ready) bus_req <= 1'b1;
          end else if (bus_gnt) begin
            st       <= ST_XFER;
            mem_en   <= 1'b1;
            mem_we   <= ~dir;
            dev_take <= ~dir;
            if (!dir) mem_wdata <= dev_rdata;
          end
        end
        ST_XFER: begin
          st      <= ST_REL;
          mem_en  <= 1'b0;
          mem_we  <= 1'b0;
          bus_req <= 1'b0;
          if (dir) begin
            dev_wdata <= mem_rdata;
            dev_put   <= 1'b1;
          end
        end
        ST_REL: begin
          st <= cnt_last ? ST_DONE : ST_REQ;
        end
        ST_DONE: begin
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign step     = (st == ST_REL);
  assign done_set = (st == ST_DONE);

  // R4
  property p_one_word;
    @(posedge clk) disable iff (rst) mem_en |=> (!mem_en && !bus_req);
  endproperty
  one_word_chk: assert property (p_one_word);

  // R3
  property p_req_ready;
    @(posedge clk) disable iff (rst) $rose(bus_req) |-> $past(dev_ready);
  endproperty
  req_ready_chk: assert property (p_req_ready);

  // R3
  property p_req_hold;
    @(posedge clk) disable iff (rst) (bus_req && !mem_en && !bus_gnt) |=> bus_req;
  endproperty
  req_hold_chk: assert property (p_req_hold);

  // R5
  property p_put_after_read;
    @(posedge clk) disable iff (rst) dev_put |-> $past(mem_en && !mem_we);
  endproperty
  put_order_chk: assert property (p_put_after_read);

endmodule

// File: rtl/steal_dma.sv
module steal_dma
  import steal_dma_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int DEVW = 8,
  parameter int RAW  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            bus_req,
  input  logic            bus_gnt,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            dev_ready,
  output logic [DEVW-1:0] dev_sel,
  input  logic [DW-1:0]   dev_rdata,
  output logic            dev_take,
  output logic [DW-1:0]   dev_wdata,
  output logic            dev_put,
  output logic            irq
);

  logic          busy, done_set, go, ld_addr, ld_cnt, dir, step;
  logic          cnt_zero, cnt_last;
  logic [CW-1:0] cnt;

  steal_dma_regs #(
    .DW(DW), .AW(AW), .CW(CW), .DEVW(DEVW), .RAW(RAW)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wr_lo    (reg_wdata[DEVW-1:0]),
    .busy     (busy),
    .done_set (done_set),
    .cur_addr (mem_addr),
    .cur_cnt  (cnt),
    .reg_rdata(reg_rdata),
    .dir      (dir),
    .dev_sel  (dev_sel),
    .done     (irq),
    .go       (go),
    .ld_addr  (ld_addr),
    .ld_cnt   (ld_cnt)
  );

  steal_dma_ctr #(
    .DW(DW), .AW(AW), .CW(CW)
  ) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .ld_addr (ld_addr),
    .ld_cnt  (ld_cnt),
    .wdata   (reg_wdata),
    .step    (step),
    .addr    (mem_addr),
    .cnt     (cnt),
    .cnt_zero(cnt_zero),
    .cnt_last(cnt_last)
  );

  steal_dma_seq #(
    .DW(DW)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .dir      (dir),
    .cnt_zero (cnt_zero),
    .cnt_last (cnt_last),
    .dev_ready(dev_ready),
    .bus_gnt  (bus_gnt),
    .mem_rdata(mem_rdata),
    .dev_rdata(dev_rdata),
    .bus_req  (bus_req),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata),
    .dev_take (dev_take),
    .dev_put  (dev_put),
    .dev_wdata(dev_wdata),
    .step     (step),
    .done_set (done_set),
    .busy     (busy)
  );

  // R6
  property p_irq_at_zero;
    @(posedge clk) disable iff (rst) $rose(irq) |-> (cnt == '0);
  endproperty
  irq_zero_chk: assert property (p_irq_at_zero);

  // R7
  property p_no_access_at_zero;
    @(posedge clk) disable iff (rst) mem_en |-> (cnt != '0);
  endproperty
  zero_idle_chk: assert property (p_no_access_at_zero);

endmodule

// File: tb/steal_dma_tb.sv
`timescale 1ns/1ps
module steal_dma_tb;

  logic        clk = 0;
  logic        rst = 1;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        bus_req, bus_gnt = 0;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        dev_ready = 1;
  logic [7:0]  dev_sel;
  logic [15:0] dev_rdata = 16'hA000;
  logic        dev_take, dev_put, irq;
  logic [15:0] dev_wdata;

  always #4 clk = ~clk;

  steal_dma u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_ready(dev_ready),
    .dev_sel(dev_sel), .dev_rdata(dev_rdata), .dev_take(dev_take),
    .dev_wdata(dev_wdata), .dev_put(dev_put), .irq(irq)
  );

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory model
  logic [15:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_en && mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  // bus and device environment, driven away from the active edge
  bit stall = 0, allow = 1, prev_ready = 1, prev_req = 0;
  int cyc = 0, take_n = 0, req_rises = 0, r3_bad = 0, en_cycles = 0;
  logic [15:0] got_q[$];

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (bus_req && !prev_req) begin
        req_rises++;
        if (!prev_ready) r3_bad++;
      end
      if (mem_en) en_cycles++;
      if (dev_take) begin take_n++; dev_rdata = 16'hA000 + 16'(take_n); end
      if (dev_put) got_q.push_back(dev_wdata);
    end
    prev_req = bus_req;
    if (stall) begin
      dev_ready = (cyc % 5) != 1;
      allow     = (cyc % 3) != 0;
    end else begin
      dev_ready = 1;
      allow     = 1;
    end
    prev_ready = dev_ready;
    bus_gnt = bus_req && allow;
  end

  // behavioural reference: phase number and expected registered outputs
  int m_ph = 0, m_addr = 0, m_cnt = 0;
  bit m_dir = 0, m_req = 0, m_en = 0, m_we = 0, m_take = 0, m_put = 0, m_irq = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_addr = 0; m_cnt = 0; m_dir = 0; m_req = 0; m_en = 0;
      m_we = 0; m_take = 0; m_put = 0; m_irq = 0;
    end else begin
      m_take = 0; m_put = 0;
      if (reg_wr && reg_addr == 4 && reg_wdata[1]) m_irq = 0;
      case (m_ph)
        0: if (reg_wr) begin
             case (reg_addr)
               2: m_addr = reg_wdata;
               3: m_cnt  = reg_wdata;
               0: begin
                    m_dir = reg_wdata[1];
                    if (reg_wdata[0]) m_ph = (m_cnt == 0) ? 4 : 1;
                  end
               default: ;
             endcase
           end
        1: if (!m_req) begin
             if (dev_ready) m_req = 1;
           end else if (bus_gnt) begin
             m_ph = 2; m_en = 1; m_we = !m_dir; m_take = !m_dir;
           end
        2: begin m_ph = 3; m_en = 0; m_we = 0; m_req = 0; m_put = m_dir; end
        3: begin m_addr = (m_addr + 1) & 16'hFFFF; m_cnt = m_cnt - 1; m_ph = (m_cnt == 0) ? 4 : 1; end
        4: begin m_irq = 1; m_ph = 0; end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) if (!rst) begin
    check(bus_req === m_req,  "R3 bus_req", bus_req, m_req);
    check(mem_en === m_en,    "R4 mem_en", mem_en, m_en);
    check(mem_addr === 16'(m_addr), "R4 mem_addr", mem_addr, m_addr);
    if (m_en) check(mem_we === m_we, "R5 mem_we", mem_we, m_we);
    check(dev_take === m_take, "R5 dev_take", dev_take, m_take);
    check(dev_put === m_put,   "R5 dev_put", dev_put, m_put);
    check(irq === m_irq,       "R9 irq", irq, m_irq);
  end

  // register access; every task starts and ends just after a falling edge
  task automatic wr(input int a, input int d);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    reg_addr = 3'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    check(irq === 1'b1, tag, irq, 1);
  endtask

  logic [15:0] v;
  int rr;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    rd(4, v);
    check(v === 16'h0, "R1 status after reset", v, 0);
    check(irq === 1'b0 && bus_req === 1'b0, "R1 outputs after reset", {irq, bus_req}, 0);

    // R2 and R10 register readback
    wr(1, 16'h5A);
    rd(1, v);
    check(v === 16'h005A, "R2 device register readback", v, 16'h5A);
    check(dev_sel === 8'h5A, "R10 dev_sel", dev_sel, 8'h5A);
    wr(0, 2);
    rd(0, v);
    check(v === 16'h0002, "R2 control direction readback", v, 2);

    // R4 R5 R6 device to memory, four words
    take_n = 0; dev_rdata = 16'hA000;
    wr(2, 16'h10); wr(3, 4); wr(0, 1);
    wait_irq("R6 irq after device-to-memory block");
    for (int k = 0; k < 4; k++)
      check(mem[16 + k] === 16'hA000 + 16'(k), "R5 memory word", mem[16 + k], 16'hA000 + k);
    check(mem[20] === 16'h0, "R4 word past end untouched", mem[20], 0);
    rd(2, v); check(v === 16'h14, "R6 final address", v, 16'h14);
    rd(3, v); check(v === 16'h0, "R6 final count", v, 0);
    rd(4, v); check(v === 16'h2, "R6 status done not busy", v, 2);

    // R9 interrupt holds, then clears
    repeat (10) @(negedge clk);
    check(irq === 1'b1, "R9 irq held", irq, 1);
    wr(4, 2);
    check(irq === 1'b0, "R9 irq cleared", irq, 0);

    // R3 R4 R5 memory to device with stalls
    for (int k = 0; k < 3; k++) mem[64 + k] = 16'h0100 + 16'(3 * k);
    got_q.delete(); r3_bad = 0; en_cycles = 0;
    stall = 1;
    wr(2, 16'h40); wr(3, 3); wr(0, 3);
    wait_irq("R6 irq after memory-to-device block");
    stall = 0;
    check(got_q.size() == 3, "R5 words delivered", got_q.size(), 3);
    for (int k = 0; k < 3 && k < got_q.size(); k++)
      check(got_q[k] === 16'h0100 + 16'(3 * k), "R5 delivered word", got_q[k], 16'h0100 + 3 * k);
    check(r3_bad == 0, "R3 request only after ready", r3_bad, 0);
    check(en_cycles == 3, "R4 one access per word", en_cycles, 3);
    wr(4, 2);

    // R8 writes while busy are ignored
    take_n = 0; dev_rdata = 16'hA000;
    wr(2, 16'h80); wr(3, 5); wr(0, 1);
    repeat (2) @(negedge clk);
    wr(3, 9); wr(2, 0); wr(0, 1); wr(1, 16'h11);
    wait_irq("R8 irq after block with busy writes");
    rd(2, v); check(v === 16'h85, "R8 address not reloaded", v, 16'h85);
    rd(3, v); check(v === 16'h0, "R8 count not reloaded", v, 0);
    check(mem[16'h84] === 16'hA004 && mem[16'h85] === 16'h0, "R8 five words only", mem[16'h85], 0);
    check(dev_sel === 8'h5A, "R8 device address kept", dev_sel, 8'h5A);
    wr(4, 2);

    // R7 zero count completes without the bus
    rr = req_rises;
    wr(3, 0); wr(0, 1);
    check(irq === 1'b0, "R7 irq one edge after start", irq, 0);
    @(negedge clk);
    check(irq === 1'b1, "R7 irq two edges after start", irq, 1);
    check(req_rises == rr, "R7 no bus request", req_rises, rr);
    wr(4, 2);

    // R9 set beats a clear in the same cycle
    wr(0, 1); wr(4, 2);
    check(irq === 1'b1, "R9 set wins over clear", irq, 1);
    wr(4, 2);
    check(irq === 1'b0, "R9 later clear", irq, 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule